// File: doc/BRIEF.md
# FPGA Configuration Stream Loader

This block is a memory-mapped peripheral that feeds a configuration bitstream into a downstream FPGA configuration port. Software first writes the image length in bytes while the loader is idle. It then sets the enable bit in the control register. The 32-bit image words then arrive at a single write-only data port, written either by the processor or by a DMA engine. The loader buffers these words in a FIFO and hands them one at a time to a word sink. That sink stands in for the serial configuration pins.

A running byte count tracks how much of the image the sink has taken. Streaming stops once that count reaches the programmed total. When the sink then reports configuration done, the loader sets a done flag and raises an interrupt. A sink error or a FIFO overflow instead sets an error flag, halts streaming and also raises the interrupt. Writing an all-zero word to the control register disables the loader, flushes the FIFO and clears the interrupt. A separate control bit drives the configuration reset line of the downstream device. In DMA-request mode the loader asks an external DMA engine for bursts of half the FIFO depth. The handshake is a request line and an acknowledge pulse.

Register reads are decoded combinationally from the address. Writes take effect at the clock edge that captures them.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset `irq`, `cfg_rst`, `dma_req` and `snk_valid` are low and the status register (0x44) reads zero.
- R2: The FIFO size register (0x48) reads FIFO_DEPTH*4 bytes. The fill register (0x4C) reads the number of buffered words times 4.
- R3: The total byte count (0x50) is written only while control bit 0 is clear. Writes while enabled are ignored, and bits 1:0 always read zero.
- R4: Setting control bit 0 (enable) while disabled clears the current count (0x54) and status bits 1, 2 and 18. Status bit 0 reads 1 while enabled, not done and error-free. Words written to the data port (0x3000) reach `snk_data` unchanged and in write order, first byte in bits 31:24, one per `snk_valid`/`snk_ready` handshake.
- R5: The current byte count rises by 4 per handshake. No word is offered once it equals the total byte count.
- R6: When the current count equals the total and `snk_done` is high, status bit 18 sets and `irq` rises on the next edge. `snk_done` before the total is reached has no effect.
- R7: Writing 0x00000000 to control (0x40) disables the loader, clears `irq` and empties the FIFO (fill register reads 0).
- R8: `cfg_rst` follows control bit 1, so writing 0x3 then 0x0 gives a reset pulse.
- R9: A data-port write while the FIFO is full is dropped. It sets status bit 2, raises `irq` and halts streaming.
- R10: `snk_error` high while enabled sets status bit 1, raises `irq` and stops `snk_valid`.
- R11: With control bits 0 and 2 set, `dma_req` rises when the FIFO has room for FIFO_DEPTH/2 words. After a `dma_ack` pulse it stays low for a burst of FIFO_DEPTH/2 data-port writes, or fewer if the total is reached. It is never raised once the accepted bytes cover the total.
- R12: Data-port writes while the loader is disabled are dropped and leave the fill register at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Load finished or failed |
| cfg_rst | output | 1 | Configuration reset to the downstream device |
| dma_req | output | 1 | Burst request to the DMA engine |
| dma_ack | input | 1 | One-cycle acknowledge of a request |
| snk_valid | output | 1 | A configuration word is offered |
| snk_data | output | 32 | Offered configuration word |
| snk_ready | input | 1 | Sink takes the word this cycle |
| snk_done | input | 1 | Downstream configuration complete |
| snk_error | input | 1 | Downstream configuration error |

## Verification
A register write is visible on a read, and on `cfg_rst`, in the cycle after its capture edge. A word pushed into an empty FIFO is offered on `snk_valid` one edge after the push. `irq`, the status flags and `dma_req` each follow their triggering condition by exactly one edge. The bench drives inputs just after the rising edge and samples everything on the falling edge. Its scoreboard therefore compares every handshake in the cycle the word leaves the FIFO. Sticky results such as flags and counts are read only after a few idle cycles, so no check depends on a race at an edge.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam logic [15:0] OFS_CTRL  = 16'h0040;
  localparam logic [15:0] OFS_STAT  = 16'h0044;
  localparam logic [15:0] OFS_SIZE  = 16'h0048;
  localparam logic [15:0] OFS_USED  = 16'h004C;
  localparam logic [15:0] OFS_TOTAL = 16'h0050;
  localparam logic [15:0] OFS_CUR   = 16'h0054;
  localparam logic [15:0] OFS_DATA  = 16'h3000;

  localparam int CTL_EN  = 0;
  localparam int CTL_RST = 1;
  localparam int CTL_DMA = 2;

  localparam int ST_BUSY     = 0;
  localparam int ST_ERR_SINK = 1;
  localparam int ST_ERR_OVF  = 2;
  localparam int ST_DONE     = 18;

  typedef enum logic [1:0] {DQ_IDLE, DQ_REQ, DQ_BURST} dreq_state_e;
endpackage

// File: rtl/cfgl_fifo.sv
module cfgl_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wr_q + AW'(1);
      if (pop)  rd_d = rd_q + AW'(1);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem_q[wr_q] <= wdata;
  end

  assign rdata = mem_q[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5
endmodule

// File: rtl/cfgl_dreq.sv
module cfgl_dreq
  import cfgl_pkg::*;
#(
  parameter int HALF = 8,
  localparam int BW  = $clog2(HALF) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic stop,
  input  logic dma_ack,
  input  logic push,
  input  logic push_last,
  output logic dma_req
);
  dreq_state_e st_q, st_d;
  logic [BW-1:0] bcnt_q, bcnt_d;

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    unique case (st_q)
      DQ_IDLE: if (arm) st_d = DQ_REQ;
      DQ_REQ: begin
        if (!arm) st_d = DQ_IDLE;
        else if (dma_ack) begin
          st_d   = DQ_BURST;
          bcnt_d = '0;
        end
      end
      DQ_BURST: begin
        if (stop) st_d = DQ_IDLE;
        else if (push) begin
          if (bcnt_q == BW'(HALF - 1) || push_last) st_d = DQ_IDLE;
          else bcnt_d = bcnt_q + BW'(1);
        end
      end
      default: st_d = DQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DQ_IDLE;
      bcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign dma_req = (st_q == DQ_REQ);

  AST_DMA_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && arm) |=> dma_req); // R11
  AST_DMA_NO_REQ_WHEN_IDLE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !dma_req) |=> !dma_req); // R11
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en,
  input  logic              clr_irq,
  input  logic [DATA_W-1:0] total,
  input  logic              fifo_empty,
  input  logic              snk_ready,
  input  logic              snk_done,
  input  logic              snk_error,
  input  logic              push_ok,
  input  logic              ovf_evt,
  output logic              pop,
  output logic              snk_valid,
  output logic [DATA_W-1:0] cur,
  output logic              acc_full,
  output logic              push_last,
  output logic              done,
  output logic              err_snk,
  output logic              err_ovf,
  output logic              irq
);
  logic [DATA_W-1:0] cur_q, cur_d, acc_q, acc_d;
  logic done_q, done_d, esnk_q, esnk_d, eovf_q, eovf_d, irq_q, irq_d;
  logic at_total, done_evt, err_any;

  always_comb begin
    at_total  = (cur_q == total);
    err_any   = esnk_q | eovf_q;
    snk_valid = en & ~err_any & ~fifo_empty & ~at_total;
    pop       = snk_valid & snk_ready;
    done_evt  = en & ~done_q & at_total & snk_done;

    cur_d  = cur_q;
    acc_d  = acc_q;
    done_d = done_q;
    esnk_d = esnk_q;
    eovf_d = eovf_q;
    if (start) begin
      cur_d  = '0;
      acc_d  = '0;
      done_d = 1'b0;
      esnk_d = 1'b0;
      eovf_d = 1'b0;
    end else begin
      if (pop)      cur_d = cur_q + DATA_W'(4);
      if (push_ok)  acc_d = acc_q + DATA_W'(4);
      if (done_evt) done_d = 1'b1;
      if (en && snk_error) esnk_d = 1'b1;
      if (ovf_evt)  eovf_d = 1'b1;
    end

    if (clr_irq) irq_d = 1'b0;
    else irq_d = irq_q | done_evt | (en & snk_error) | ovf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      esnk_q <= 1'b0;
      eovf_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      esnk_q <= esnk_d;
      eovf_q <= eovf_d;
      irq_q  <= irq_d;
    end
  end

  assign cur       = cur_q;
  assign acc_full  = (acc_q >= total);
  assign push_last = ((acc_q + DATA_W'(4)) >= total);
  assign done      = done_q;
  assign err_snk   = esnk_q;
  assign err_ovf   = eovf_q;
  assign irq       = irq_q;

  AST_CUR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cur_q <= total)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_irq) |=> irq_q); // R7
  AST_NO_STREAM_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    esnk_q |-> !snk_valid); // R10
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !clr_irq) |=> irq_q); // R6
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgl_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32,
  localparam int HALF      = FIFO_DEPTH / 2,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [15:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              cfg_rst,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ready,
  input  logic              snk_done,
  input  logic              snk_error
);
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic [2:0]        ctrl_q, ctrl_d;
  logic [DATA_W-1:0] total_q, total_d;
  logic wr_ctrl, wr_total, wr_data, en, start, clr_irq;
  logic push_ok, ovf_evt, pop, fifo_full, fifo_empty;
  logic [CW-1:0] fifo_cnt;
  logic [DATA_W-1:0] cur;
  logic acc_full, push_last, done, err_snk, err_ovf, err_any, dma_arm;

  always_comb begin
    wr_ctrl  = bus_wr_en && (bus_addr == OFS_CTRL);
    wr_total = bus_wr_en && (bus_addr == OFS_TOTAL);
    wr_data  = bus_wr_en && (bus_addr == OFS_DATA);
    en       = ctrl_q[CTL_EN];
    start    = wr_ctrl && bus_wdata[CTL_EN] && !en;
    clr_irq  = wr_ctrl && (bus_wdata == '0);
    push_ok  = wr_data && en && !fifo_full;
    ovf_evt  = wr_data && en && fifo_full;
    err_any  = err_snk | err_ovf;
    dma_arm  = en && ctrl_q[CTL_DMA] && !err_any && !acc_full &&
               ((CW'(FIFO_DEPTH) - fifo_cnt) >= CW'(HALF));
    ctrl_d   = wr_ctrl ? bus_wdata[2:0] : ctrl_q;
    total_d  = (wr_total && !en) ? {bus_wdata[DATA_W-1:2], 2'b00} : total_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q  <= '0;
      total_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      total_q <= total_d;
    end
  end

  cfgl_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .flush(!en), .push(push_ok),
    .wdata(bus_wdata), .pop(pop), .rdata(snk_data), .count(fifo_cnt),
    .full(fifo_full), .empty(fifo_empty)
  );

  cfgl_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .start(start), .en(en), .clr_irq(clr_irq),
    .total(total_q), .fifo_empty(fifo_empty), .snk_ready(snk_ready),
    .snk_done(snk_done), .snk_error(snk_error), .push_ok(push_ok),
    .ovf_evt(ovf_evt), .pop(pop), .snk_valid(snk_valid), .cur(cur),
    .acc_full(acc_full), .push_last(push_last), .done(done),
    .err_snk(err_snk), .err_ovf(err_ovf), .irq(irq)
  );

  cfgl_dreq #(.HALF(HALF)) u_dreq (
    .clk(clk), .rst_n(rst_s_n), .arm(dma_arm), .stop(!en || err_any),
    .dma_ack(dma_ack), .push(push_ok), .push_last(push_last),
    .dma_req(dma_req)
  );

  assign cfg_rst = ctrl_q[CTL_RST];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      OFS_STAT: begin
        bus_rdata[ST_BUSY]     = en & ~done & ~err_any;
        bus_rdata[ST_ERR_SINK] = err_snk;
        bus_rdata[ST_ERR_OVF]  = err_ovf;
        bus_rdata[ST_DONE]     = done;
      end
      OFS_SIZE:  bus_rdata = DATA_W'(FIFO_DEPTH * 4);
      OFS_USED:  bus_rdata = DATA_W'({fifo_cnt, 2'b00});
      OFS_TOTAL: bus_rdata = total_q;
      OFS_CUR:   bus_rdata = cur;
      default:   bus_rdata = '0;
    endcase
  end

  AST_TOTAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (en && $past(en)) |-> $stable(total_q)); // R3
  AST_NO_PUSH_DISABLED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!en) |=> (fifo_cnt == '0)); // R12
endmodule

// File: tb/test_cfg_stream_loader.sv
`timescale 1ns/1ps
module test_cfg_stream_loader;
  localparam int DEPTH = 16;
  localparam logic [15:0] A_CTRL = 16'h0040, A_STAT = 16'h0044, A_SIZE = 16'h0048,
                          A_USED = 16'h004C, A_TOT = 16'h0050, A_CUR = 16'h0054,
                          A_DATA = 16'h3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, cfg_rst, dma_req, snk_valid;
  logic dma_ack = 1'b0;
  logic [31:0] snk_data;
  logic snk_ready = 1'b0, snk_done = 1'b0, snk_error = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  cfg_stream_loader #(.FIFO_DEPTH(DEPTH)) i_cfg_stream_loader (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cfg_rst(cfg_rst),
    .dma_req(dma_req), .dma_ack(dma_ack), .snk_valid(snk_valid),
    .snk_data(snk_data), .snk_ready(snk_ready), .snk_done(snk_done),
    .snk_error(snk_error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: a handshake seen at the falling edge completes at the next rising edge
  always @(negedge clk) begin
    if (rst_n && snk_valid && snk_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 unexpected word actual=0x%08h expected=none", snk_data);
      end else begin
        chk("R4 stream order", snk_data, exp_q.pop_front());
      end
    end
  end

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic put_word(input logic [31:0] d, input bit expect_out);
    if (expect_out) exp_q.push_back(d);
    bus_wr(A_DATA, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_req(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (dma_req) begin seen = 1'b1; break; end
    end
  endtask

  task automatic pulse_ack();
    @(posedge clk); #2; dma_ack = 1'b1;
    @(posedge clk); #2; dma_ack = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 cfg_rst", {31'd0, cfg_rst}, 0);
    chk("R1 dma_req", {31'd0, dma_req}, 0);
    chk("R1 snk_valid", {31'd0, snk_valid}, 0);
    bus_rd(A_STAT, v); chk("R1 status", v, 0);

    // R2 size and fill registers
    bus_rd(A_SIZE, v); chk("R2 fifo size", v, DEPTH * 4);
    bus_rd(A_USED, v); chk("R2 fifo used empty", v, 0);

    // R3 total count: low bits dropped, frozen while enabled
    bus_wr(A_TOT, 32'h0000_001B);
    bus_rd(A_TOT, v); chk("R3 total low bits", v, 32'h18);
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_TOT, 32'h0000_0100);
    bus_rd(A_TOT, v); chk("R3 total frozen", v, 32'h18);
    bus_wr(A_CTRL, 32'h0);

    // R12 data writes while disabled
    put_word(32'hDEAD_0001, 1'b0);
    put_word(32'hDEAD_0002, 1'b0);
    bus_rd(A_USED, v); chk("R12 used after disabled writes", v, 0);
    idle(2);
    chk("R12 no output", {31'd0, snk_valid}, 0);

    // R4/R5/R6 processor load of 6 words
    bus_wr(A_TOT, 32'd24);
    snk_ready = 1'b1; snk_done = 1'b1;
    bus_wr(A_CTRL, 32'h1);
    idle(3);
    chk("R6 early done ignored irq", {31'd0, irq}, 0);
    bus_rd(A_STAT, v); chk("R6 early done ignored status", v, 32'h1);
    for (int i = 0; i < 6; i++) put_word(32'hA0B1_C200 + i, 1'b1);
    idle(4);
    bus_rd(A_CUR, v); chk("R5 current count", v, 24);
    bus_rd(A_STAT, v); chk("R6 done flag", v & 32'h0004_0000, 32'h0004_0000);
    chk("R6 irq", {31'd0, irq}, 1);
    put_word(32'h5555_0000, 1'b0);
    put_word(32'h5555_0001, 1'b0);
    idle(3);
    chk("R5 nothing past total", {31'd0, snk_valid}, 0);
    bus_rd(A_CUR, v); chk("R5 count held", v, 24);
    bus_rd(A_USED, v); chk("R2 used two words", v, 8);
    snk_done = 1'b0;

    // R7 zero write
    bus_wr(A_CTRL, 32'h0);
    idle(1);
    chk("R7 irq cleared", {31'd0, irq}, 0);
    bus_rd(A_USED, v); chk("R7 fifo flushed", v, 0);

    // R4 restart clears count and flags
    bus_wr(A_CTRL, 32'h1);
    bus_rd(A_STAT, v); chk("R4 status after restart", v, 32'h1);
    bus_rd(A_CUR, v); chk("R4 count after restart", v, 0);
    bus_wr(A_CTRL, 32'h0);

    // R8 reset pulse
    bus_wr(A_CTRL, 32'h3);
    @(negedge clk); chk("R8 cfg_rst high", {31'd0, cfg_rst}, 1);
    bus_wr(A_CTRL, 32'h0);
    @(negedge clk); chk("R8 cfg_rst low", {31'd0, cfg_rst}, 0);

    // R9 overflow
    bus_wr(A_TOT, 32'd400);
    snk_ready = 1'b0;
    bus_wr(A_CTRL, 32'h1);
    for (int i = 0; i < DEPTH + 1; i++) put_word(32'hF00D_0000 + i, 1'b0);
    idle(2);
    bus_rd(A_USED, v); chk("R9 used full", v, DEPTH * 4);
    bus_rd(A_STAT, v); chk("R9 overflow flag", v & 32'h4, 32'h4);
    chk("R9 irq", {31'd0, irq}, 1);
    snk_ready = 1'b1;
    idle(3);
    chk("R9 streaming halted", {31'd0, snk_valid}, 0);
    bus_rd(A_CUR, v); chk("R9 count zero", v, 0);
    bus_wr(A_CTRL, 32'h0);

    // R10 sink error
    bus_wr(A_TOT, 32'd40);
    bus_wr(A_CTRL, 32'h1);
    put_word(32'h1234_5678, 1'b1);
    put_word(32'h9ABC_DEF0, 1'b1);
    idle(3);
    @(posedge clk); #2 snk_error = 1'b1;
    @(posedge clk); #2 snk_error = 1'b0;
    idle(1);
    bus_rd(A_STAT, v); chk("R10 error flag", v & 32'h2, 32'h2);
    chk("R10 irq", {31'd0, irq}, 1);
    put_word(32'h0BAD_0BAD, 1'b0);
    idle(2);
    chk("R10 valid stopped", {31'd0, snk_valid}, 0);
    bus_rd(A_CUR, v); chk("R10 count", v, 8);
    bus_wr(A_CTRL, 32'h0);

    // R11 DMA-request mode, 12 words = 8 + 4
    bus_wr(A_TOT, 32'd48);
    bus_wr(A_CTRL, 32'h5);
    wait_req(seen);
    chk("R11 first request", {31'd0, seen}, 1);
    idle(2);
    chk("R11 request held", {31'd0, dma_req}, 1);
    pulse_ack();
    @(negedge clk); chk("R11 request dropped after ack", {31'd0, dma_req}, 0);
    for (int i = 0; i < DEPTH / 2; i++) put_word(32'hD0A0_0000 + i, 1'b1);
    wait_req(seen);
    chk("R11 second request", {31'd0, seen}, 1);
    pulse_ack();
    for (int i = 0; i < 4; i++) put_word(32'hD0A1_0000 + i, 1'b1);
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dma_req) seen = 1'b1;
    end
    chk("R11 no request past total", {31'd0, seen}, 0);
    bus_rd(A_CUR, v); chk("R5 dma count", v, 48);
    snk_done = 1'b1;
    idle(2);
    chk("R6 dma irq", {31'd0, irq}, 1);
    snk_done = 1'b0;
    bus_wr(A_CTRL, 32'h0);

    idle(2);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule